// File: doc/BRIEF.md
# Serial Byte-Memory Slave Port

This block is the serial front end of a small byte-wide memory that stands in for a nonvolatile store. A four-wire serial master (clock, data in, data out, active-low select) reaches the memory through it. An active-low pause input is also provided. A fast system clock oversamples every pin through two-flop synchronisers. The block acts only on the edges of the synchronised serial clock. It never drives the serial clock. The first byte after select falls is a command. For memory reads and writes, that byte also carries the ninth address bit. An address byte follows. The block returns read data on a data/enable pair that drives a tri-state pad. Each write is handed to a separate write controller. That controller holds the store and runs a timed write cycle.

Inside the block, the command decoder passes a write to the write controller over a valid/ready link. The decoder raises valid with a fixed address and data byte. It holds all three unchanged until ready is seen high on a clock edge. The controller shows ready only while no write cycle is running. One transfer is made on each edge where valid and ready are both high. The block also keeps a write-enable latch and a two-bit protect field. Both can be read back through the status command.

Top module: `spi_nvm_slave`

## Requirements
- R1: Bits travel most significant first. Input bits are taken on the rising edge of the serial clock. The output bit changes only on the falling edge, so a master samples it on the next rising edge.
- R2: The first byte after select falls is decoded as a command. The codes are: set-enable 0x06, clear-enable 0x04, status read 0x05, status write 0x01, memory read 0000_A011 and memory write 0000_A010. Here A is address bit 8. It is used only when DEPTH is 512.
- R3: A memory read returns the byte at the given address after the address byte. It then goes on with the following addresses. It wraps from DEPTH-1 to 0 for as long as select stays low.
- R4: A memory write stores only the first full data byte that follows the address. The store happens when select rises, and only if the enable latch is set and the address is not protected. Further data bytes are ignored. A write that ends with a full data byte always clears the enable latch.
- R5: Set-enable and clear-enable set and clear the enable latch. A status read returns bit0 = write cycle busy, bit1 = enable latch, bits 3:2 = protect field, and zeros above. The status byte repeats for as long as select stays low.
- R6: A status write with the enable latch set copies data bits 3:2 into the protect field and clears the latch. Without the latch set, it changes nothing.
- R7: The protect field blocks writes to a region of the memory. 0 blocks nothing. 1 blocks addresses at or above 3*DEPTH/4. 2 blocks addresses at or above DEPTH/2. 3 blocks all addresses.
- R8: After an unknown command, the block takes no further input and keeps the output disabled until select rises. The next falling edge of select starts a fresh command.
- R9: While select is high, the serial input is ignored and the output is disabled. Raising select in the middle of a command abandons that command.
- R10: Pulling the pause input low while the serial clock is low freezes the transfer. During the pause, clock edges and the serial input are ignored and the output is disabled. Releasing the pause while the clock is low resumes the transfer at the bit where it stopped.
- R11: An accepted write holds the write cycle busy for WR_CYCLES system clocks. During that time, every command except status read is treated as unknown (R8). The write request is passed over valid/ready and held stable until it is accepted.
- R12: After reset the memory holds zeros, the enable latch and the protect field are clear, and the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so_d | output | 1 | Serial data out, meaningful when so_oe is high |
| so_oe | output | 1 | Output enable for the tri-state SO pad |

## Verification
A bit counter that is off by one shows up within one byte. Every data byte after it comes back rotated, and the next command decodes as unknown, so the output stays disabled. A latch or protect field in the wrong state shows on the next status read, or as a missing or unexpected change in the memory read back right after the write cycle ends. A pause or mute flag that is stuck shows immediately: the output is enabled while it should be dark, or a read returns no data at all.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [2:0] OP_MEM_RD_LO = 3'b011;
  localparam logic [2:0] OP_MEM_WR_LO = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRRD, ST_SRWR, ST_MUTE
  } link_state_t;

  function automatic logic [7:0] pack_status(logic busy, logic wel, logic [1:0] bp);
    return {4'b0000, bp, wel, busy};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int DEPTH = 512,
  parameter int WR_CYCLES = 2000,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          busy
);
  logic [7:0]    mem [DEPTH];
  logic [TW-1:0] tmr;

  assign wr_ready = (tmr == '0);
  assign busy     = (tmr != '0);
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      tmr          <= TW'(WR_CYCLES);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> busy); // R11
  AST_DATA_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> mem[$past(wr_addr)] == $past(wr_data)); // R4
endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
  import spi_nvm_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int Q3 = (DEPTH / 4) * 3,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          cs_n_s,
  input  logic          si_s,
  input  logic          hold_n_s,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          busy,
  output logic          so_d,
  output logic          so_oe
);
  link_state_t   st;
  logic          sck_d, cs_d, hold_act, so_live, wel, a8, is_rd, wfull;
  logic [1:0]    bp;
  logic [2:0]    bcnt;
  logic [6:0]    sh;
  logic [7:0]    out_sr, nb;
  logic [AW-1:0] ptr, addr_new;

  wire cs_act   = ~cs_n_s;
  wire cs_fall  = cs_act & cs_d;
  wire cs_rise  = cs_n_s & ~cs_d;
  wire sck_rise = cs_act & ~hold_act & sck_s & ~sck_d;
  wire sck_fall = cs_act & ~hold_act & ~sck_s & sck_d;
  wire out_st   = (st == ST_RDATA) || (st == ST_SRRD);
  wire in_st    = (st == ST_OPC) || (st == ST_ADDR) || out_st ||
                  (st == ST_WDATA) || (st == ST_SRWR);

  assign nb = {sh, si_s};

  generate
    if (AW >= 9) begin : g_a8
      assign addr_new = AW'({a8, nb});
    end else begin : g_no_a8
      assign addr_new = nb[AW-1:0];
    end
  endgenerate

  function automatic logic is_prot(logic [AW-1:0] a, logic [1:0] f);
    case (f)
      2'd0:    return 1'b0;
      2'd1:    return 32'(a) >= Q3;
      2'd2:    return 32'(a) >= HALF;
      default: return 1'b1;
    endcase
  endfunction

  assign rd_addr = (st == ST_ADDR) ? addr_new : ptr + 1'b1;
  assign so_d    = out_sr_q;
  assign so_oe   = cs_act & ~hold_act & so_live;

  logic out_sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_act <= 1'b0;
    else if (!cs_act) hold_act <= 1'b0;
    else if (!sck_s) hold_act <= ~hold_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bcnt <= '0; sh <= '0; out_sr <= '0; out_sr_q <= 1'b0;
      so_live <= 1'b0; wel <= 1'b0; bp <= '0; a8 <= 1'b0; is_rd <= 1'b0;
      wfull <= 1'b0; ptr <= '0; wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (cs_fall) begin
        st <= ST_OPC; bcnt <= '0; wfull <= 1'b0; so_live <= 1'b0;
      end else if (cs_rise) begin
        st <= ST_IDLE; wfull <= 1'b0; so_live <= 1'b0;
        if (wfull) begin
          wel <= 1'b0;
          if (wel && !is_prot(ptr, bp)) begin
            wr_valid <= 1'b1;
            wr_addr  <= ptr;
          end
        end
      end else begin
        if (sck_fall && out_st) begin
          out_sr_q <= out_sr[7];
          out_sr   <= {out_sr[6:0], 1'b0};
          so_live  <= 1'b1;
        end
        if (sck_rise && in_st) begin
          sh   <= nb[6:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == 3'd7) begin
            case (st)
              ST_OPC: begin
                if (busy && nb != OP_STAT_RD) st <= ST_MUTE;
                else if (nb == OP_SET_WEL) begin wel <= 1'b1; st <= ST_IDLE; end
                else if (nb == OP_CLR_WEL) begin wel <= 1'b0; st <= ST_IDLE; end
                else if (nb == OP_STAT_RD) begin
                  out_sr <= pack_status(busy, wel, bp); st <= ST_SRRD;
                end
                else if (nb == OP_STAT_WR) st <= ST_SRWR;
                else if (nb[7:4] == 4'h0 && nb[2:0] == OP_MEM_RD_LO) begin
                  a8 <= nb[3]; is_rd <= 1'b1; st <= ST_ADDR;
                end
                else if (nb[7:4] == 4'h0 && nb[2:0] == OP_MEM_WR_LO) begin
                  a8 <= nb[3]; is_rd <= 1'b0; st <= ST_ADDR;
                end
                else st <= ST_MUTE;
              end
              ST_ADDR: begin
                ptr <= addr_new;
                if (is_rd) begin out_sr <= rd_data; st <= ST_RDATA; end
                else st <= ST_WDATA;
              end
              ST_RDATA: begin
                ptr    <= ptr + 1'b1;
                out_sr <= rd_data;
              end
              ST_SRRD: out_sr <= pack_status(busy, wel, bp);
              ST_SRWR: begin
                if (wel) begin bp <= nb[3:2]; wel <= 1'b0; end
                st <= ST_IDLE;
              end
              ST_WDATA: begin
                wr_data <= nb; wfull <= 1'b1; st <= ST_IDLE;
              end
              default: st <= st;
            endcase
          end
        end
      end
    end
  end

  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(out_sr_q)); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R11
  AST_WEL_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> !wel); // R4
  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !is_prot(wr_addr, bp)); // R7
  AST_MUTE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_MUTE && !cs_rise |=> st == ST_MUTE && !so_oe); // R8
  AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> !$past(sck_s)); // R10
  AST_DESEL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe); // R9
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int DEPTH = 512,
  parameter int WR_CYCLES = 2000,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic so_d,
  output logic so_oe
);
  logic          sck_s, cs_n_s, si_s, hold_n_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          wr_valid, wr_ready, busy;

  spi_pin_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, hold_n, si}),
    .q({cs_n_s, sck_s, hold_n_s, si_s})
  );

  spi_nvm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .si_s(si_s),
    .hold_n_s(hold_n_s), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .so_d(so_d), .so_oe(so_oe)
  );

  nvm_store #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy)
  );

  AST_RESET_DARK: assert property (@(posedge clk) $rose(rst_n) |-> !so_oe); // R12
endmodule

// File: tb/spi_nvm_slave_test.sv
module spi_nvm_slave_test;
  localparam int DEPTH = 512;
  localparam int WRC = 800;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  wire  so_d, so_oe;
  always #4 clk = ~clk;

  spi_nvm_slave #(.DEPTH(DEPTH), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .so_d(so_d), .so_oe(so_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0, oe_any, oe_all;
  logic [7:0] expm [DEPTH];
  logic [7:0] rx;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clkn(int n); repeat (n) @(negedge clk); endtask

  task automatic bitx(input logic b, output logic r);
    si = b; clkn(H);
    r = so_d; oe_any |= so_oe; oe_all &= so_oe;
    sck = 1'b1; clkn(H); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitx(tx[i], r[i]);
  endtask

  task automatic sel(); cs_n = 1'b0; clkn(H); endtask
  task automatic desel(); clkn(H); cs_n = 1'b1; clkn(2 * H); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic stat(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    logic [7:0] d;
    sel();
    xfer({4'h0, 1'(a >> 8), 3'b010}, d);
    xfer(8'(a), d);
    xfer(v, d);
    desel();
  endtask

  task automatic rd_burst(input int a, input int n, input string req);
    logic [7:0] d;
    sel();
    xfer({4'h0, 1'(a >> 8), 3'b011}, d);
    xfer(8'(a), d);
    for (int k = 0; k < n; k++) begin
      oe_all = 1'b1;
      xfer(8'h00, d);
      chk(oe_all && d == expm[(a + k) % DEPTH], req, d, expm[(a + k) % DEPTH]);
    end
    desel();
  endtask

  task automatic set_bp(input logic [1:0] f);
    cmd1(8'h06);
    sel(); xfer(8'h01, rx); xfer({4'h0, f, 2'b00}, rx); desel();
  endtask

  function automatic int sweep_addr(int i);
    case (i)
      0: return 0;     1: return 127;  2: return 128;  3: return 255;
      4: return 256;   5: return 383;  6: return 384;  7: return 511;
      default: return (i * 37 + 5) % DEPTH;
    endcase
  endfunction

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + 8'h5A) ^ (a >> 1));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) expm[i] = 8'h00;
    clkn(5); rst_n = 1'b1; clkn(5);

    chk(so_oe == 1'b0, "R12 reset output", so_oe, 0);
    stat(rx); chk(rx == 8'h00, "R12 R5 reset status", rx, 8'h00);

    cmd1(8'h06);
    sel(); xfer(8'h05, rx); xfer(8'h00, rx);
    chk(rx == 8'h02, "R5 R2 enable set", rx, 8'h02);
    xfer(8'h00, rx); chk(rx == 8'h02, "R5 status repeats", rx, 8'h02);
    desel();
    cmd1(8'h04); stat(rx); chk(rx == 8'h00, "R5 enable clear", rx, 8'h00);

    wr(5, 8'hA7); clkn(WRC + 100);
    rd_burst(5, 1, "R4 write without enable");

    for (int i = 0; i < 24; i++) begin
      int a = sweep_addr(i);
      cmd1(8'h06);
      wr(a, pat(a));
      expm[a] = pat(a);
      if (i == 0) begin
        stat(rx); chk(rx == 8'h01, "R11 R4 busy and enable spent", rx, 8'h01);
        sel(); oe_any = 1'b0;
        xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx);
        chk(!oe_any, "R11 read rejected while busy", oe_any, 0);
        desel();
      end
      clkn(WRC + 100);
    end
    stat(rx); chk(rx == 8'h00, "R11 busy ends", rx, 8'h00);

    rd_burst(0, DEPTH + 4, "R3 R2 R1 burst read and wrap");
    rd_burst(510, 4, "R3 wrap at top");

    sel(); oe_any = 1'b0;
    xfer(8'hFF, rx); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx);
    chk(!oe_any, "R8 unknown command mute", oe_any, 0);
    desel();
    rd_burst(0, 1, "R8 fresh command after mute");

    cmd1(8'h06);
    sel(); xfer(8'h02, rx); xfer(8'd20, rx); xfer(8'hC3, rx); xfer(8'h3C, rx); desel();
    expm[20] = 8'hC3; clkn(WRC + 100);
    rd_burst(20, 1, "R4 only first data byte");

    sel(); xfer(8'h01, rx); xfer(8'h0C, rx); desel();
    stat(rx); chk(rx == 8'h00, "R6 status write without enable", rx, 8'h00);
    set_bp(2'd3); stat(rx); chk(rx == 8'h0C, "R6 protect stored", rx, 8'h0C);
    cmd1(8'h06); wr(0, 8'h11); clkn(WRC + 100);
    rd_burst(0, 1, "R7 all protected");
    set_bp(2'd1);
    cmd1(8'h06); wr(511, 8'h22); clkn(WRC + 100);
    cmd1(8'h06); wr(384, 8'h23); clkn(WRC + 100);
    cmd1(8'h06); wr(383, 8'h24); expm[383] = 8'h24; clkn(WRC + 100);
    rd_burst(383, 2, "R7 quarter protect");
    rd_burst(511, 1, "R7 quarter protect top");
    set_bp(2'd2);
    cmd1(8'h06); wr(256, 8'h33); clkn(WRC + 100);
    cmd1(8'h06); wr(255, 8'h34); expm[255] = 8'h34; clkn(WRC + 100);
    rd_burst(255, 2, "R7 half protect");
    set_bp(2'd0); stat(rx); chk(rx == 8'h00, "R6 protect cleared", rx, 8'h00);

    begin
      logic [7:0] d;
      logic [7:0] v;
      sel(); xfer(8'h03, d); xfer(8'h00, d);
      oe_all = 1'b1;
      for (int i = 7; i >= 5; i--) bitx(1'b0, v[i]);
      hold_n = 1'b0; clkn(H); oe_any = 1'b0;
      for (int t = 0; t < 4; t++) begin
        si = t[0]; sck = 1'b1; clkn(H); oe_any |= so_oe; sck = 1'b0; clkn(H); oe_any |= so_oe;
      end
      chk(!oe_any, "R10 output dark during pause", oe_any, 0);
      hold_n = 1'b1; clkn(H);
      for (int i = 4; i >= 0; i--) bitx(1'b0, v[i]);
      chk(oe_all && v == expm[0], "R10 resume in place", v, expm[0]);
      oe_all = 1'b1; xfer(8'h00, d);
      chk(oe_all && d == expm[1], "R10 next byte after pause", d, expm[1]);
      desel();
    end

    chk(so_oe == 1'b0, "R9 deselected output", so_oe, 0);
    oe_any = 1'b0;
    for (int t = 0; t < 16; t++) begin
      si = t[1]; sck = ~sck; clkn(H); oe_any |= so_oe;
    end
    sck = 1'b0; clkn(H);
    chk(!oe_any, "R9 input ignored while deselected", oe_any, 0);
    sel(); bitx(1'b0, rx[0]); bitx(1'b0, rx[0]); bitx(1'b0, rx[0]); desel();
    rd_burst(383, 1, "R9 abandoned command");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule